// File: doc/BRIEF.md
# Twin-predicated element index sequencer

This block generates the element index pairs for a two-operand move-type operation, such as a register copy, a splat, an insert, an extract, a gather or a scatter. A single start pulse loads a vector length, a source predicate mask and a destination predicate mask. It also loads, for each side, a flag that marks the operand as a vector and a flag that selects zeroing. The sequencer then offers one step per cycle on a valid/ready handshake. Each step carries a source element index, a destination element index, and a flag that tells the datapath to write zero instead of the source element. The register data itself never passes through the block.

Each side skips its own masked-out elements independently of the other. Because of this, a single loop produces every predicated copy pattern. A scalar side stays at element 0 and never skips. When the destination is a scalar, the operation ends after its first write. The current source and destination offsets are always visible, so that a trap handler can save them.

Top module: `tps_twin_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low, and the configuration is captured at that edge. A start pulse that arrives while busy has no effect on the running step sequence.
- R2: The vector length in use is `vl_i`, with two exceptions: a value of 0 is treated as 1, and a value above MAXVL is treated as MAXVL.
- R3: When the source is a vector and source zeroing is off, every issued source index k is a position where bit k (LSB = element 0) of the source mask is set. The block moves to the next set bit at or after its current offset within the same cycle.
- R4: When the destination is a vector and destination zeroing is off, every issued destination index k is a position where bit k of the destination mask is set. It advances exactly as in R3.
- R5: After each accepted step, the source offset moves one past the issued source index only if the source is a vector. The destination offset follows the same rule. A scalar side always issues index 0.
- R6: The operation ends in either of two cases: an index reaches the vector length, or a skip scan finds no set bit below the vector length. In that cycle `busy_o` falls, and `done_o` is high for exactly one cycle after the last busy cycle.
- R7: When the destination is a scalar, exactly one step is issued. This also covers a scalar-to-scalar operation.
- R8: `step_zero_o` is high when destination zeroing is on and destination mask bit j is clear. It is also high when source zeroing is on and source mask bit i is clear. When both flags are set, either clear bit is enough.
- R9: A step completes only in a cycle in which `step_ready_i` is high. While it is held, `step_valid_o` and all step fields stay unchanged.
- R10: After a step has been held for one cycle, `ctx_src_off_o` and `ctx_dst_off_o` equal the held step's indices. Both offsets read zero while the block is idle.
- R11: During and after reset, `busy_o`, `step_valid_o` and `done_o` are low and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation with the configuration below |
| vl_i | input | VL_IN_W | Requested vector length |
| src_mask_i | input | MAXVL | Source predicate, bit k = element k |
| dst_mask_i | input | MAXVL | Destination predicate, bit k = element k |
| src_vec_i | input | 1 | Source operand is a vector |
| dst_vec_i | input | 1 | Destination operand is a vector |
| src_zero_i | input | 1 | Source zeroing mode |
| dst_zero_i | input | 1 | Destination zeroing mode |
| step_ready_i | input | 1 | Consumer accepts the offered step |
| step_valid_o | output | 1 | A step is offered |
| step_src_idx_o | output | $clog2(MAXVL) | Source element index |
| step_dst_idx_o | output | $clog2(MAXVL) | Destination element index |
| step_zero_o | output | 1 | Write zero instead of source data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse after the operation ends |
| ctx_src_off_o | output | $clog2(MAXVL+1) | Saved source element offset |
| ctx_dst_off_o | output | $clog2(MAXVL+1) | Saved destination element offset |

## Verification
If a cursor holds a wrong offset, the next offered index shows it at the ports in the same cycle. That index lands on a masked-out element, repeats, or skips a set one. If the step is held for one more cycle, the offset also shows on the context outputs. A wrong end condition shows up as an extra or missing step, or as a late `done_o` pulse, at the end of the operation. A wrong zeroing decision shows up on `step_zero_o` in the step where the affected mask bit is clear. Each scenario is compared step by step against a sequence that the bench computes from the requirements.

// File: rtl/tps_pkg.sv
package tps_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic is_vec;
      logic zeroing;
   } side_mode_t;

   localparam int SIDE_SRC = 0;
   localparam int SIDE_DST = 1;
   localparam int N_SIDES  = 2;

endpackage

// File: rtl/tps_first_set.sv
module tps_first_set #(
   parameter int N       = 16,
   parameter int IW      = 4,
   parameter bit ISOLATE = 1'b0
) (
   input  logic [N-1:0]  bits_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);

   assign found_o = |bits_i;

   generate
      if (ISOLATE) begin : g_isolate
         // keep the lowest set bit only, then OR-encode its position
         logic [N-1:0] lowest;
         assign lowest = bits_i & (~bits_i + N'(1));
         always_comb begin
            idx_o = '0;
            for (int k = 0; k < N; k++) begin
               if (lowest[k]) idx_o = idx_o | IW'(k);
            end
         end
      end else begin : g_loop
         // downward scan: the last hit written is the lowest set bit
         always_comb begin
            idx_o = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (bits_i[k]) idx_o = IW'(k);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tps_lane_cursor.sv
module tps_lane_cursor
   import tps_pkg::*;
#(
   parameter int N       = 16,
   parameter int IW      = 4,
   parameter int CW      = 5,
   parameter bit ISOLATE = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clear_i,
   input  logic          run_i,
   input  logic          fire_i,
   input  side_mode_t    mode_i,
   input  logic [N-1:0]  mask_i,
   input  logic [CW-1:0] vl_i,
   output logic          ok_o,
   output logic [IW-1:0] idx_o,
   output logic          last_o,
   output logic          bit_o,
   output logic [CW-1:0] off_o
);

   logic [CW-1:0] cur_q;
   logic [CW-1:0] eff;
   logic [CW-1:0] adv;
   logic [N-1:0]  window;
   logic          scan_found;
   logic [IW-1:0] scan_idx;
   logic          skip_en;

   assign skip_en = mode_i.is_vec & ~mode_i.zeroing;

   // candidate elements: set in the mask, at or after the offset, below the length
   always_comb begin
      for (int k = 0; k < N; k++) begin
         window[k] = mask_i[k] && (CW'(k) >= cur_q) && (CW'(k) < vl_i);
      end
   end

   tps_first_set #(
      .N       (N),
      .IW      (IW),
      .ISOLATE (ISOLATE)
   ) u_scan (
      .bits_i  (window),
      .found_o (scan_found),
      .idx_o   (scan_idx)
   );

   assign eff    = skip_en ? CW'(scan_idx) : cur_q;
   assign ok_o   = skip_en ? scan_found : (cur_q < vl_i);
   assign adv    = mode_i.is_vec ? eff + CW'(1) : eff;
   assign last_o = mode_i.is_vec && (adv >= vl_i);
   assign idx_o  = eff[IW-1:0];
   assign bit_o  = mask_i[idx_o];
   assign off_o  = cur_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q <= '0;
      end else if (clear_i) begin
         cur_q <= '0;
      end else if (run_i) begin
         cur_q <= fire_i ? adv : eff;
      end
   end

endmodule

// File: rtl/tps_twin_seq.sv
module tps_twin_seq
   import tps_pkg::*;
#(
   parameter int MAXVL        = 16,
   parameter int VL_IN_W      = 8,
   parameter bit ISOLATE_SCAN = 1'b0,
   localparam int IW = $clog2(MAXVL),
   localparam int CW = $clog2(MAXVL + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [VL_IN_W-1:0] vl_i,
   input  logic [MAXVL-1:0]   src_mask_i,
   input  logic [MAXVL-1:0]   dst_mask_i,
   input  logic               src_vec_i,
   input  logic               dst_vec_i,
   input  logic               src_zero_i,
   input  logic               dst_zero_i,
   input  logic               step_ready_i,
   output logic               step_valid_o,
   output logic [IW-1:0]      step_src_idx_o,
   output logic [IW-1:0]      step_dst_idx_o,
   output logic               step_zero_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [CW-1:0]      ctx_src_off_o,
   output logic [CW-1:0]      ctx_dst_off_o
);

   generate
      if (MAXVL < 2 || MAXVL > 64 || (MAXVL & (MAXVL - 1)) != 0) begin : g_bad_maxvl
         $error("MAXVL must be a power of two from 2 to 64");
      end
      if (VL_IN_W < CW) begin : g_bad_vlw
         $error("VL_IN_W too narrow for MAXVL");
      end
   endgenerate

   seq_state_e                          state_q;
   logic [CW-1:0]                       vl_q;
   logic [CW-1:0]                       vl_clamped;
   logic [N_SIDES-1:0][MAXVL-1:0]       mask_q;
   side_mode_t [N_SIDES-1:0]            mode_q;
   logic                                done_q;

   logic                                accept;
   logic                                running;
   logic                                fire;
   logic                                finish;
   logic                                both_ok;

   logic [N_SIDES-1:0]                  side_ok;
   logic [N_SIDES-1:0]                  side_last;
   logic [N_SIDES-1:0]                  side_bit;
   logic [N_SIDES-1:0][IW-1:0]          side_idx;
   logic [N_SIDES-1:0][CW-1:0]          side_off;

   assign running = (state_q == SEQ_RUN);
   assign accept  = start_i && !running;

   // the requested length is truncated into 1..MAXVL
   always_comb begin
      if (vl_i == '0) begin
         vl_clamped = CW'(1);
      end else if (vl_i > VL_IN_W'(MAXVL)) begin
         vl_clamped = CW'(MAXVL);
      end else begin
         vl_clamped = vl_i[CW-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vl_q   <= CW'(1);
         mask_q <= '0;
         mode_q <= '0;
      end else if (accept) begin
         vl_q             <= vl_clamped;
         mask_q[SIDE_SRC] <= src_mask_i;
         mask_q[SIDE_DST] <= dst_mask_i;
         mode_q[SIDE_SRC] <= '{is_vec: src_vec_i, zeroing: src_zero_i};
         mode_q[SIDE_DST] <= '{is_vec: dst_vec_i, zeroing: dst_zero_i};
      end
   end

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         tps_lane_cursor #(
            .N       (MAXVL),
            .IW      (IW),
            .CW      (CW),
            .ISOLATE (ISOLATE_SCAN)
         ) u_cursor (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (!running || finish),
            .run_i   (running),
            .fire_i  (fire),
            .mode_i  (mode_q[s]),
            .mask_i  (mask_q[s]),
            .vl_i    (vl_q),
            .ok_o    (side_ok[s]),
            .idx_o   (side_idx[s]),
            .last_o  (side_last[s]),
            .bit_o   (side_bit[s]),
            .off_o   (side_off[s])
         );
      end
   endgenerate

   assign both_ok = &side_ok;
   assign fire    = running && both_ok && step_ready_i;

   // end: a scan ran dry, or the accepted step exhausts an index or fills a scalar
   assign finish = running &&
                   (!both_ok ||
                    (fire && (!mode_q[SIDE_DST].is_vec || (|side_last))));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept) begin
            state_q <= SEQ_RUN;
         end else if (finish) begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   assign step_valid_o   = running && both_ok;
   assign step_src_idx_o = side_idx[SIDE_SRC];
   assign step_dst_idx_o = side_idx[SIDE_DST];
   assign step_zero_o    = (mode_q[SIDE_SRC].zeroing && !side_bit[SIDE_SRC]) ||
                           (mode_q[SIDE_DST].zeroing && !side_bit[SIDE_DST]);
   assign busy_o         = running;
   assign done_o         = done_q;
   assign ctx_src_off_o  = side_off[SIDE_SRC];
   assign ctx_dst_off_o  = side_off[SIDE_DST];

endmodule

// File: rtl/tps_twin_seq_chk.sv
module tps_twin_seq_chk #(
   parameter int MAXVL = 16,
   localparam int IW = $clog2(MAXVL),
   localparam int CW = $clog2(MAXVL + 1)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             step_valid,
   input logic             step_ready,
   input logic [IW-1:0]    src_idx,
   input logic [IW-1:0]    dst_idx,
   input logic             zero,
   input logic             busy,
   input logic             done,
   input logic [CW-1:0]    ctx_src,
   input logic [CW-1:0]    ctx_dst,
   input logic [CW-1:0]    vl_cfg,
   input logic [MAXVL-1:0] src_mask_cfg,
   input logic [MAXVL-1:0] dst_mask_cfg,
   input logic             src_skip,
   input logic             dst_skip,
   input logic             dst_vec
);

   // R9
   valid_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid |-> busy);

   // R6
   idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid |-> (CW'(src_idx) < vl_cfg) && (CW'(dst_idx) < vl_cfg));

   // R9
   stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid && !step_ready |=> step_valid && $stable(src_idx) &&
                                    $stable(dst_idx) && $stable(zero));

   // R10
   ctx_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid && !step_ready |=> (ctx_src == CW'($past(src_idx))) &&
                                    (ctx_dst == CW'($past(dst_idx))));

   // R10
   idle_ctx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy |-> (ctx_src == '0) && (ctx_dst == '0));

   // R7
   scalar_dst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid && step_ready && !dst_vec |=> !busy);

   // R3
   src_skip_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid && src_skip |-> src_mask_cfg[src_idx]);

   // R4
   dst_skip_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_valid && dst_skip |-> dst_mask_cfg[dst_idx]);

   // R6
   done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done |-> !busy && $past(busy));

endmodule

bind tps_twin_seq tps_twin_seq_chk #(.MAXVL(MAXVL)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .step_valid   (step_valid_o),
   .step_ready   (step_ready_i),
   .src_idx      (step_src_idx_o),
   .dst_idx      (step_dst_idx_o),
   .zero         (step_zero_o),
   .busy         (busy_o),
   .done         (done_o),
   .ctx_src      (ctx_src_off_o),
   .ctx_dst      (ctx_dst_off_o),
   .vl_cfg       (vl_q),
   .src_mask_cfg (mask_q[0]),
   .dst_mask_cfg (mask_q[1]),
   .src_skip     (mode_q[0].is_vec && !mode_q[0].zeroing),
   .dst_skip     (mode_q[1].is_vec && !mode_q[1].zeroing),
   .dst_vec      (mode_q[1].is_vec)
);

// File: tb/test_tps_twin_seq.sv
module test_tps_twin_seq;

   localparam int MAXVL = 16;
   localparam int VW    = 8;
   localparam int IW    = 4;
   localparam int CW    = 5;

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic             start_i = 1'b0;
   logic [VW-1:0]    vl_i = '0;
   logic [MAXVL-1:0] src_mask_i = '0;
   logic [MAXVL-1:0] dst_mask_i = '0;
   logic             src_vec_i = 1'b0;
   logic             dst_vec_i = 1'b0;
   logic             src_zero_i = 1'b0;
   logic             dst_zero_i = 1'b0;
   logic             step_ready_i = 1'b0;
   logic             step_valid_o;
   logic [IW-1:0]    step_src_idx_o;
   logic [IW-1:0]    step_dst_idx_o;
   logic             step_zero_o;
   logic             busy_o;
   logic             done_o;
   logic [CW-1:0]    ctx_src_off_o;
   logic [CW-1:0]    ctx_dst_off_o;

   always #10 clk_i = ~clk_i;

   tps_twin_seq #(.MAXVL(MAXVL), .VL_IN_W(VW)) i_tps_twin_seq (
      .clk_i, .rst_ni, .start_i, .vl_i, .src_mask_i, .dst_mask_i,
      .src_vec_i, .dst_vec_i, .src_zero_i, .dst_zero_i, .step_ready_i,
      .step_valid_o, .step_src_idx_o, .step_dst_idx_o, .step_zero_o,
      .busy_o, .done_o, .ctx_src_off_o, .ctx_dst_off_o
   );

   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   // one operation: model from the requirements, drive, capture, compare
   task automatic run_op(input int vl, input logic [MAXVL-1:0] sm,
                         input logic [MAXVL-1:0] dm, input bit sv, input bit dv,
                         input bit sz, input bit dz, input bit stall,
                         input bit poke, input string req);
      int es[64], ed[64], ez[64], cs[64], cd[64], cz[64];
      int ne = 0, nc = 0, ve, i = 0, j = 0, cyc = 0;
      bit prev_stall = 0, timed_out = 0;
      int ps = 0, pd = 0;
      ve = (vl == 0) ? 1 : ((vl > MAXVL) ? MAXVL : vl);
      forever begin
         if (sv && !sz) while (i < ve && !sm[i]) i++;
         if (dv && !dz) while (j < ve && !dm[j]) j++;
         if (i >= ve || j >= ve) break;
         es[ne] = i; ed[ne] = j;
         ez[ne] = ((sz && !sm[i]) || (dz && !dm[j])) ? 1 : 0;
         ne++;
         if (!dv) break;
         if (sv) i++;
         j++;
         if (i >= ve || j >= ve) break;
      end

      @(negedge clk_i);
      start_i = 1'b1; vl_i = VW'(vl); src_mask_i = sm; dst_mask_i = dm;
      src_vec_i = sv; dst_vec_i = dv; src_zero_i = sz; dst_zero_i = dz;
      @(negedge clk_i);
      start_i = 1'b0;
      forever begin
         if (done_o) break;
         step_ready_i = !(stall && (cyc % 3 != 2));
         if (poke && cyc == 1) begin
            // R1: start while busy with a different configuration
            start_i = 1'b1; vl_i = VW'(3); src_mask_i = '0; dst_mask_i = '0;
         end else begin
            start_i = 1'b0;
         end
         if (prev_stall && step_valid_o) begin
            check(int'(step_src_idx_o) == ps && int'(step_dst_idx_o) == pd,
                  "R9", "held index", int'(step_src_idx_o), ps);
            check(int'(ctx_src_off_o) == ps && int'(ctx_dst_off_o) == pd,
                  "R10", "context offset", int'(ctx_src_off_o), ps);
         end
         prev_stall = step_valid_o && !step_ready_i;
         ps = int'(step_src_idx_o);
         pd = int'(step_dst_idx_o);
         if (step_valid_o && step_ready_i && nc < 64) begin
            cs[nc] = int'(step_src_idx_o);
            cd[nc] = int'(step_dst_idx_o);
            cz[nc] = int'(step_zero_o);
            nc++;
         end
         @(negedge clk_i);
         cyc++;
         if (cyc > 400) begin
            timed_out = 1;
            break;
         end
      end
      start_i = 1'b0;
      step_ready_i = 1'b0;
      check(!timed_out, "R6", "done pulse seen", timed_out, 0);
      check(nc == ne, req, "step count", nc, ne);
      for (int k = 0; k < ne && k < nc; k++) begin
         check(cs[k] == es[k], req, "source index", cs[k], es[k]);
         check(cd[k] == ed[k], req, "destination index", cd[k], ed[k]);
         check(cz[k] == ez[k], req, "zero flag", cz[k], ez[k]);
      end
      check(!busy_o, "R6", "busy after end", busy_o, 0);
      @(negedge clk_i);
      check(!done_o, "R6", "done width", done_o, 0);
      check(ctx_src_off_o == 0 && ctx_dst_off_o == 0, "R10", "idle offsets",
            int'(ctx_src_off_o), 0);
   endtask

   task automatic t_reset();
      rst_ni = 1'b0;
      repeat (3) @(negedge clk_i);
      check(!busy_o && !step_valid_o && !done_o, "R11", "outputs in reset",
            int'({busy_o, step_valid_o, done_o}), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check(!busy_o && !step_valid_o && !done_o, "R11", "outputs after reset",
            int'({busy_o, step_valid_o, done_o}), 0);
      check(ctx_src_off_o == 0 && ctx_dst_off_o == 0, "R11", "offsets after reset",
            int'(ctx_src_off_o), 0);
   endtask

   // R5 R6: plain vector copy
   task automatic t_copy();
      run_op(5, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R5");
   endtask

   // R4 R5: scalar source splatted over set destination bits
   task automatic t_splat();
      run_op(8, 16'h0000, 16'h00B2, 0, 1, 0, 0, 0, 0, "R4");
   endtask

   // R3 R7: first set source element into a scalar
   task automatic t_extract();
      run_op(8, 16'h0024, 16'h0000, 1, 0, 0, 0, 0, 0, "R3");
   endtask

   // R3 R4: both sides skip independently
   task automatic t_gather_scatter();
      run_op(8, 16'h00B6, 16'h006D, 1, 1, 0, 0, 0, 0, "R3");
   endtask

   // R8: destination zeroing
   task automatic t_dst_zero();
      run_op(8, 16'hFFFF, 16'h0053, 1, 1, 0, 1, 0, 0, "R8");
   endtask

   // R8: both sides zeroing
   task automatic t_both_zero();
      run_op(8, 16'h00E5, 16'h00BE, 1, 1, 1, 1, 0, 0, "R8");
   endtask

   // R7: scalar to scalar
   task automatic t_scalar_scalar();
      run_op(6, 16'h0000, 16'h0000, 0, 0, 0, 0, 0, 0, "R7");
   endtask

   // R2: length truncation at both ends
   task automatic t_clamp();
      run_op(20, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R2");
      run_op(0, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R2");
   endtask

   // R6: source scan finds nothing
   task automatic t_empty();
      run_op(8, 16'h0000, 16'hFFFF, 1, 1, 0, 0, 0, 0, "R6");
   endtask

   // R9 R10: stalled handshake
   task automatic t_stall();
      run_op(7, 16'h0066, 16'h00F1, 1, 1, 0, 0, 1, 0, "R9");
   endtask

   // R1: start pulse during a run is ignored
   task automatic t_ignore_start();
      run_op(8, 16'hFFFF, 16'hFFFF, 1, 1, 0, 0, 0, 1, "R1");
   endtask

   initial begin
      t_reset();
      t_copy();
      t_splat();
      t_extract();
      t_gather_scatter();
      t_dst_zero();
      t_both_zero();
      t_scalar_scalar();
      t_clamp();
      t_empty();
      t_stall();
      t_ignore_start();
      finish_run();
   end

endmodule